// File: doc/BRIEF.md
# Packed Subword SIMD ALU

A vector datapath unit for 64-bit register operands. Each operand is split into packed lanes whose width is chosen per operation: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. In every lane the unit adds, subtracts, multiplies or does a multiply-accumulate. No carry, borrow or product bit ever passes from one lane into the next.

An operation arrives as two 64-bit operands, a lane-width select, an opcode and a destination index, qualified by a valid strobe. The result goes into an internal 64-entry by 64-bit vector register file. In the same cycle it appears on the result port with a done strobe. Add and subtract finish in one cycle. Multiply and multiply-accumulate go through a two-stage pipeline. The accumulate form reads its accumulator from the destination entry of the register file in the second stage, so a chain of accumulations into one entry needs no forwarding.

Top module: `psimd_alu`

## Requirements
- R1: The lane select picks the element width: 2'b00 gives eight 8-bit lanes, 2'b01 gives four 16-bit lanes, 2'b10 gives two 32-bit lanes, and the reserved code 2'b11 behaves exactly like 2'b10.
- R2: Opcode 2'b00 (add) produces in each lane the lane sum modulo 2^width. No carry propagates into the neighbouring lane.
- R3: Opcode 2'b01 (subtract, a minus b) produces in each lane the difference modulo 2^width. No borrow propagates across a lane boundary.
- R4: Opcode 2'b10 (multiply) produces in each lane the low width bits of the product of the two lane elements.
- R5: Opcode 2'b11 (multiply-accumulate) produces in each lane the low product plus the matching lane of the current contents of the destination register, wrapping modulo 2^width.
- R6: An add or subtract accepted at a clock edge raises done at that same edge. The result and destination index are valid for one cycle.
- R7: A multiply or multiply-accumulate accepted at a clock edge raises done one edge later, that is two cycles of latency. Such operations may be issued on every cycle.
- R8: Each completed result is written into the register-file entry named by its destination index at the edge that raises done. A later multiply-accumulate with a zero multiplicand returns that stored value.
- R9: An add or subtract issued in the cycle directly after a multiply or multiply-accumulate is discarded. It raises no done of its own and writes nothing. The earlier operation completes normally.
- R10: While reset is asserted, done is low.
- R11: Done is never raised without a matching accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | Opcode: 00 add, 01 sub, 10 mul, 11 mac |
| in_lane | input | 2 | Lane width select |
| in_dst | input | 6 | Destination register index |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Done: result written this cycle |
| out_dst | output | 6 | Register index just written |
| out_data | output | 64 | Result just written |

## Verification
The bench builds the unit with its defaults: a 64-bit datapath, an 8-bit lane segment and 64 registers. These values give all three lane splits and the reserved code, with the 0xFF+1 and 0-1 patterns placed right on lane boundaries, and 32-bit products large enough to overflow. The shadow register file in the scoreboard makes back-to-back accumulation chains and read-back through the accumulate path checkable. Every completion is also checked for its exact cycle, which exposes both latencies and the discard rule for a short operation that follows a long one.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_MAC = 2'b11
    } psimd_op_e;

    // Lane width in units of the smallest segment: 8-bit -> 1, 16 -> 2, 32 (and reserved) -> 4
    function automatic int seg_span(input logic [1:0] lane);
        case (lane)
            2'b00:   return 1;
            2'b01:   return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/psimd_laneadd.sv
module psimd_laneadd #(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 8
) (
    input  logic [1:0]        lane,
    input  logic              sub,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum
);
    import psimd_pkg::*;

    localparam int NSEG = DATA_W / SEG_W;

    logic [DATA_W-1:0] b_eff;
    logic [SEG_W:0]    part;
    logic              carry;
    logic              cin;
    int                span;

    assign b_eff = sub ? ~b : b;

    always_comb begin
        span  = seg_span(lane);
        carry = 1'b0;
        part  = '0;
        cin   = 1'b0;
        sum   = '0;
        for (int i = 0; i < NSEG; i++) begin
            // a segment that opens a lane takes the subtract's +1 instead of the neighbour carry
            cin  = ((i % span) == 0) ? sub : carry;
            part = {1'b0, a[i*SEG_W +: SEG_W]} + {1'b0, b_eff[i*SEG_W +: SEG_W]}
                 + {{SEG_W{1'b0}}, cin};
            sum[i*SEG_W +: SEG_W] = part[SEG_W-1:0];
            carry = part[SEG_W];
        end
    end

endmodule

// File: rtl/psimd_lanemul.sv
module psimd_lanemul #(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 8
) (
    input  logic [1:0]        lane,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] prod
);
    localparam int NMODE = 3;

    logic [DATA_W-1:0] per_mode [NMODE];

    for (genvar gm = 0; gm < NMODE; gm++) begin : g_mode
        localparam int LW = SEG_W << gm;
        localparam int NL = DATA_W / LW;
        for (genvar gl = 0; gl < NL; gl++) begin : g_lane
            // product truncated to the lane width: only the low half is kept
            assign per_mode[gm][gl*LW +: LW] = a[gl*LW +: LW] * b[gl*LW +: LW];
        end
    end

    always_comb begin
        case (lane)
            2'b00:   prod = per_mode[0];
            2'b01:   prod = per_mode[1];
            default: prod = per_mode[2];
        endcase
    end

endmodule

// File: rtl/psimd_vrf.sv
module psimd_vrf #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 64,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/psimd_alu.sv
module psimd_alu #(
    parameter  int DATA_W = 64,
    parameter  int SEG_W  = 8,
    parameter  int DEPTH  = 64,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [1:0]        in_lane,
    input  logic [AW-1:0]     in_dst,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [AW-1:0]     out_dst,
    output logic [DATA_W-1:0] out_data
);
    import psimd_pkg::*;

    typedef struct packed {
        logic              vld;
        logic              mac;
        logic [1:0]        lane;
        logic [AW-1:0]     dst;
        logic [DATA_W-1:0] prod;
    } mul_stage_t;

    typedef struct packed {
        mul_stage_t        ms;
        logic              done;
        logic [AW-1:0]     dst;
        logic [DATA_W-1:0] data;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] addsub_res;
    logic [DATA_W-1:0] prod_res;
    logic [DATA_W-1:0] acc_rd;
    logic [DATA_W-1:0] acc_opnd;
    logic [DATA_W-1:0] mac_res;
    logic              is_long;

    assign is_long  = in_op[1];
    assign acc_opnd = st_q.ms.mac ? acc_rd : '0;

    psimd_laneadd #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_addsub (
        .lane (in_lane),
        .sub  (in_op == OP_SUB),
        .a    (in_a),
        .b    (in_b),
        .sum  (addsub_res)
    );

    psimd_lanemul #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_mul (
        .lane (in_lane),
        .a    (in_a),
        .b    (in_b),
        .prod (prod_res)
    );

    psimd_laneadd #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_acc (
        .lane (st_q.ms.lane),
        .sub  (1'b0),
        .a    (st_q.ms.prod),
        .b    (acc_opnd),
        .sum  (mac_res)
    );

    psimd_vrf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_vrf (
        .clk   (clk),
        .we    (st_d.done),
        .waddr (st_d.dst),
        .wdata (st_d.data),
        .raddr (st_q.ms.dst),
        .rdata (acc_rd)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ms.vld  = in_valid && is_long;
        st_d.ms.mac  = (in_op == OP_MAC);
        st_d.ms.lane = in_lane;
        st_d.ms.dst  = in_dst;
        st_d.ms.prod = prod_res;
        if (st_q.ms.vld) begin
            // second stage owns the write port; a short op in the same slot is dropped
            st_d.done = 1'b1;
            st_d.dst  = st_q.ms.dst;
            st_d.data = mac_res;
        end else if (in_valid && !is_long) begin
            st_d.done = 1'b1;
            st_d.dst  = in_dst;
            st_d.data = addsub_res;
        end else begin
            st_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.done;
    assign out_dst   = st_q.dst;
    assign out_data  = st_q.data;

endmodule

// File: rtl/psimd_alu_chk.sv
module psimd_alu_chk #(
    parameter  int DATA_W = 64,
    parameter  int SEG_W  = 8,
    parameter  int DEPTH  = 64,
    localparam int AW     = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_op,
    input logic [1:0]        in_lane,
    input logic [AW-1:0]     in_dst,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic              out_valid,
    input logic [AW-1:0]     out_dst,
    input logic [DATA_W-1:0] out_data
);
    logic          long_q;
    logic [AW-1:0] long_dst_q;
    logic          v1_q, v2_q;
    logic [SEG_W-1:0] seg0_sum, seg1_sum;

    assign seg0_sum = in_a[SEG_W-1:0] + in_b[SEG_W-1:0];
    assign seg1_sum = in_a[2*SEG_W-1:SEG_W] + in_b[2*SEG_W-1:SEG_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            long_q     <= 1'b0;
            long_dst_q <= '0;
            v1_q       <= 1'b0;
            v2_q       <= 1'b0;
        end else begin
            long_q     <= in_valid && in_op[1];
            long_dst_q <= in_dst;
            v1_q       <= in_valid;
            v2_q       <= v1_q;
        end
    end

    p_short_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_op[1] && !long_q |=> out_valid && out_dst == $past(in_dst));

    p_long_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_op[1] |=> ##1 (out_valid && out_dst == $past(in_dst, 2)));

    p_short_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_op[1] && long_q |=> out_valid && out_dst == $past(long_dst_q));

    p_no_spurious_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> v1_q || v2_q);

    p_byte_lanes_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_op == 2'b00 && in_lane == 2'b00 && !long_q
        |=> out_data[SEG_W-1:0] == $past(seg0_sum)
            && out_data[2*SEG_W-1:SEG_W] == $past(seg1_sum));

    p_reset_quiet_r10: assert property (@(posedge clk) !rst_n |=> !out_valid);

endmodule

bind psimd_alu psimd_alu_chk #(.DATA_W(DATA_W), .SEG_W(SEG_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_psimd_alu.sv
module sim_psimd_alu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = '0;
    logic [1:0]  in_lane = '0;
    logic [5:0]  in_dst = '0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [5:0]  out_dst;
    logic [63:0] out_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done_flag = 1'b0;
    bit last_long = 1'b0;

    logic [63:0] shadow [64];
    logic [5:0]  q_dst [$];
    logic [63:0] q_dat [$];
    int          q_cyc [$];
    string       q_tag [$];
    string       q_lat [$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    psimd_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_lane(in_lane), .in_dst(in_dst), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_dst(out_dst), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [1:0] op, input logic [1:0] lane,
                                          input logic [63:0] a, input logic [63:0] b,
                                          input logic [63:0] acc);
        int w;
        logic [63:0] r, m, x, y, c, t;
        w = (lane == 2'b00) ? 8 : (lane == 2'b01) ? 16 : 32;
        m = (64'h1 << w) - 64'h1;
        r = '0;
        for (int l = 0; l < 64 / w; l++) begin
            x = (a >> (l*w)) & m;
            y = (b >> (l*w)) & m;
            c = (acc >> (l*w)) & m;
            case (op)
                2'b00:   t = x + y;
                2'b01:   t = x - y;
                2'b10:   t = x * y;
                default: t = x * y + c;
            endcase
            r = r | ((t & m) << (l*w));
        end
        return r;
    endfunction

    // driver: pushes the expected completion into the scoreboard
    task automatic issue(input logic [1:0] op, input logic [1:0] lane, input logic [5:0] dst,
                         input logic [63:0] a, input logic [63:0] b, input string tag);
        logic [63:0] e;
        bit dropped;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_lane = lane; in_dst = dst; in_a = a; in_b = b;
        dropped = last_long && !op[1];
        if (!dropped) begin
            e = model(op, lane, a, b, (op == 2'b11) ? shadow[dst] : 64'h0);
            shadow[dst] = e;
            q_dst.push_back(dst);
            q_dat.push_back(e);
            q_cyc.push_back(cyc + (op[1] ? 2 : 1));
            q_tag.push_back(tag);
            q_lat.push_back(op[1] ? "R7" : "R6");
        end
        last_long = op[1];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        last_long = 1'b0;
    endtask

    // monitor: pops and compares every completion
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_dst.size() == 0) begin
                chk(1'b0, "R11 unexpected done", {58'h0, out_dst}, 64'h0);
            end else begin
                logic [5:0] ed;
                logic [63:0] ev;
                int ec;
                string et, el;
                ed = q_dst.pop_front(); ev = q_dat.pop_front(); ec = q_cyc.pop_front();
                et = q_tag.pop_front(); el = q_lat.pop_front();
                chk(out_data == ev, et, out_data, ev);
                chk(out_dst == ed, {et, " R8 dst"}, {58'h0, out_dst}, {58'h0, ed});
                chk(cyc == ec, {el, " latency"}, 64'(cyc), 64'(ec));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] s;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10 done low in reset", {63'h0, out_valid}, 64'h0);
        rst_n = 1'b1;
        idle(2);

        // preload registers 0..3 and 11
        for (int r = 0; r < 4; r++) issue(2'b00, 2'b00, 6'(r), 64'h1111_1111_1111_1111 * (r+1), 64'h0, "R8 preload");
        issue(2'b00, 2'b10, 6'd11, 64'hCAFE_F00D_1234_5678, 64'h0, "R8 preload");
        idle(2);

        // R2 carry isolation in every lane split, R1 reserved code
        issue(2'b00, 2'b00, 6'd20, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, "R2 add 8-bit lanes");
        issue(2'b00, 2'b01, 6'd21, 64'h00FF_00FF_00FF_FFFF, 64'h0001_0001_0001_0001, "R2 add 16-bit lanes");
        issue(2'b00, 2'b10, 6'd22, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, "R2 add 32-bit lanes");
        issue(2'b00, 2'b11, 6'd23, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, "R1 reserved code as 32-bit");
        // R3 borrow isolation
        issue(2'b01, 2'b00, 6'd24, 64'h0, 64'h0101_0101_0101_0101, "R3 sub 8-bit lanes");
        issue(2'b01, 2'b01, 6'd25, 64'h0001_0000_0005_0000, 64'h0002_0001_0003_0001, "R3 sub 16-bit lanes");
        issue(2'b01, 2'b10, 6'd26, 64'h0000_0000_8000_0000, 64'h0000_0001_8000_0001, "R3 sub 32-bit lanes");
        idle(1);
        // R4 truncated products
        issue(2'b10, 2'b00, 6'd27, 64'h10FF_0203_10FF_0203, 64'h10FF_0405_10FF_0405, "R4 mul 8-bit lanes");
        issue(2'b10, 2'b01, 6'd28, 64'h00FF_1234_FFFF_0100, 64'h00FF_0010_FFFF_0100, "R4 mul 16-bit lanes");
        issue(2'b10, 2'b10, 6'd29, 64'hFFFF_FFFF_0001_0000, 64'h0000_0002_0001_0000, "R4 mul 32-bit lanes");
        issue(2'b10, 2'b11, 6'd30, 64'h8000_0001_0000_0003, 64'h0000_0002_0000_0005, "R1 R4 reserved code mul");
        idle(2);
        // R5 accumulate chain into one register, back to back
        issue(2'b11, 2'b00, 6'd1, 64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010, "R5 mac 8-bit");
        issue(2'b11, 2'b00, 6'd1, 64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010, "R5 mac chain");
        issue(2'b11, 2'b01, 6'd2, 64'hFFFF_0002_0003_0004, 64'hFFFF_0003_0004_0005, "R5 mac 16-bit");
        issue(2'b11, 2'b10, 6'd3, 64'hFFFF_FFFF_0000_0010, 64'h0000_0003_0000_0010, "R5 mac 32-bit wrap");
        idle(2);
        // R8 write then read back through mac with zero multiplicand
        issue(2'b10, 2'b01, 6'd9, 64'h0003_0005_0007_0009, 64'h0002_0002_0002_0002, "R4 mul to r9");
        idle(1);
        issue(2'b11, 2'b00, 6'd9, 64'hDEAD_BEEF_DEAD_BEEF, 64'h0, "R8 read back r9");
        idle(2);
        // R9 short op straight after a long op is discarded; r11 keeps its value
        issue(2'b10, 2'b00, 6'd10, 64'h0303_0303_0303_0303, 64'h0505_0505_0505_0505, "R9 long op completes");
        issue(2'b00, 2'b00, 6'd11, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R9 discarded");
        idle(2);
        issue(2'b11, 2'b10, 6'd11, 64'h1234, 64'h0, "R9 r11 unchanged");
        idle(2);

        // mixed stream over registers 0..3
        s = 64'h9E37_79B9_7F4A_7C15;
        for (int k = 0; k < 40; k++) begin
            logic [63:0] a, b;
            s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
            a = s;
            s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
            b = s;
            issue(a[1:0], b[1:0], {4'h0, a[9:8]}, a, b, "R2 R3 R4 R5 mixed stream");
            if (b[12]) idle(1);
        end
        idle(4);
        chk(q_dst.size() == 0, "R11 scoreboard drained", 64'(q_dst.size()), 64'h0);

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule